// File: doc/BRIEF.md
# Serial Transceiver with Loop and Single-Wire Pin Steering

This block is an asynchronous serial transmitter and receiver that share one 8-bit control register. Software writes a byte into the transmitter through a valid/ready port, and receives bytes through a second valid/ready port. Each received byte carries a parity error flag and a framing error flag. The frame engine supports 8 or 9 data bits, with optional even or odd parity. A 16x oversampling tick comes from a plain clock divider.

The block does not own its pads. For each of the two serial pins it produces:
- an output value,
- an output enable,
- an open-drain qualifier.

A chip-level direction register supplies one direction bit per pin. The control register chooses how the receiver is fed and how the transmit pad is driven:
- **Normal operation:** the receiver listens on its own pin.
- **Internal loop:** the receiver hears the transmitter directly.
- **Single wire:** the receiver listens on the transmit pad, which may be released so that another device can drive it.

In the looped modes the receive pin is given up to general-purpose output. Wired-OR drive turns every enabled output into a low-only driver.

Top module: `sci_loopwire`

## Requirements
- R1: The control register resets to 0x00 and is read back on `cfg_rdata` one cycle after a write. Its bit positions are: bit 7 loop enable, bit 6 wired-OR, bit 5 pad source, bit 4 nine-bit mode, bit 3 and bit 2 stored only (they have no effect on the datapath), bit 1 parity enable, bit 0 odd parity.
- R2: A frame is one low start bit, then 8 data bits (nine-bit mode clear) or 9 data bits (set) sent LSB first, then one high stop bit. Each bit lasts 16 ticks, and a tick is TICK_DIV clocks. The line idles high.
- R3: With parity enabled, the top data bit of the frame is replaced by a parity bit computed over the lower data bits. The ones count over all data bits including parity is even when the odd bit is 0 and odd when it is 1. The receiver raises `rx_perr` on a mismatch, and `rx_data` holds all received data bits with bit 8 = 0 in 8-bit mode.
- R4: The receiver takes the majority of samples 7, 8 and 9 of each bit. A start bit whose majority is high is dropped without output. It raises `rx_ferr` if the stop bit is low. `rx_valid` stays high until `rx_ready` is seen. After a frame, a new start is only accepted once the line has been high.
- R5: When looping is not active, the receiver reads `rxd_in`, `txd_oe` equals `tx_en`, `txd_o` carries the serial line, and `rxd_oe` is 0.
- R6: Looping is active only when loop enable, `tx_en` and `rx_en` are all set. Otherwise the pins behave as in R5.
- R7: With looping active and pad source 0, the receiver is fed from the internal transmit line. The TXD pad carries the serial line when `txd_dir` is 1, and is driven high when `txd_dir` is 0.
- R8: With looping active and pad source 1, the receiver is fed from `txd_in`. The TXD pad carries the serial line when `txd_dir` is 1, and is undriven (`txd_oe` = 0) when `txd_dir` is 0.
- R9: With looping active, the RXD pad is a general-purpose output: `rxd_oe` = `rxd_dir` and `rxd_o` = `rxd_gpio`.
- R10: With wired-OR set, `txd_od` and `rxd_od` are 1 and an output enable is asserted only while its value is 0. With wired-OR clear, both levels are driven.
- R11: All pad outputs are registered and change on the first clock edge after their inputs change.
- R12: `tx_ready` is 1 only while `tx_en` is 1 and no frame is being sent. A byte is taken when `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| txd_dir | input | 1 | Direction bit of the TXD pin (1 = output) |
| rxd_dir | input | 1 | Direction bit of the RXD pin (1 = output) |
| rxd_gpio | input | 1 | General-purpose value for RXD when looping |
| tx_data | input | 9 | Byte (or 9-bit word) to send |
| tx_valid | input | 1 | Transmit data valid |
| tx_ready | output | 1 | Transmitter can accept data |
| rx_data | output | 9 | Received data bits |
| rx_perr | output | 1 | Parity error of the held frame |
| rx_ferr | output | 1 | Framing error of the held frame |
| rx_valid | output | 1 | Received frame available |
| rx_ready | input | 1 | Consumer takes the received frame |
| txd_in | input | 1 | TXD pad input level |
| rxd_in | input | 1 | RXD pad input level |
| txd_o | output | 1 | TXD pad output value |
| txd_oe | output | 1 | TXD pad output enable |
| txd_od | output | 1 | TXD pad open-drain qualifier |
| rxd_o | output | 1 | RXD pad output value |
| rxd_oe | output | 1 | RXD pad output enable |
| rxd_od | output | 1 | RXD pad open-drain qualifier |

## Verification
The frame engine is swept over all eight combinations of word length, parity enable and parity sense. Four data words are sent in each combination: all zeros, all ones and two alternating patterns. Together these separate bit-order, length and parity-sense mistakes.

In normal mode the transmit waveform is decoded bit by bit from the pad. Frames injected on the receive pin separate good data from a flipped parity bit, a low stop bit and a short start glitch. Pin steering is checked in every loop, source, direction and wired-OR combination:
- one transfer through the internal path,
- one transfer through the pad path,
- one transfer that must not arrive, because the pad is released and pulled high.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int OVS      = 16;
  localparam int PH_W     = $clog2(OVS);
  localparam int SMP_A    = OVS / 2 - 1;
  localparam int SMP_B    = OVS / 2;
  localparam int SMP_C    = OVS / 2 + 1;

  typedef struct packed {
    logic loop_en;
    logic od_en;
    logic src_pad;
    logic nine;
    logic spare_a;
    logic spare_b;
    logic par_en;
    logic par_odd;
  } ctl_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sci_baud.sv
module sci_baud #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(TICK_DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sci_tx.sv
module sci_tx
  import sci_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [8:0] data,
  input  logic       valid,
  output logic       ready,
  output logic       line
);
  logic [10:0]     sr;
  logic [8:0]      body;
  logic [3:0]      left;
  logic [PH_W-1:0] ph;
  logic            busy;

  always_comb begin
    body = nine ? data : {1'b1, data[7:0]};
    if (par_en) begin
      if (nine) body[8] = (^data[7:0]) ^ par_odd;
      else      body[7] = (^data[6:0]) ^ par_odd;
    end
  end

  assign ready = en & ~busy;
  assign line  = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '1;
      busy <= 1'b0;
      ph   <= '0;
      left <= '0;
    end else if (!busy) begin
      if (valid && ready) begin
        sr   <= {1'b1, body, 1'b0};
        busy <= 1'b1;
        ph   <= '0;
        left <= nine ? 4'd10 : 4'd9;
      end
    end else if (tick) begin
      if (ph == PH_W'(OVS - 1)) begin
        ph <= '0;
        sr <= {1'b1, sr[10:1]};
        if (left == 4'd0) busy <= 1'b0;
        else              left <= left - 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sci_rx.sv
module sci_rx
  import sci_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       line_in,
  output logic [8:0] data,
  output logic       valid,
  input  logic       ready,
  output logic       perr,
  output logic       ferr
);
  logic            s1, s2, sa, sb, busy, seen_high;
  logic [PH_W-1:0] ph;
  logic [3:0]      idx;
  logic [8:0]      sh;
  logic            vote;
  logic [3:0]      stop_idx;

  assign vote     = maj3(sa, sb, s2);
  assign stop_idx = nine ? 4'd10 : 4'd9;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; sa <= 1'b1; sb <= 1'b1;
      busy <= 1'b0; seen_high <= 1'b0; ph <= '0; idx <= '0; sh <= '0;
      data <= '0; valid <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      if (valid && ready) valid <= 1'b0;
      if (!busy) begin
        if (tick) begin
          if (s2) seen_high <= 1'b1;
          else if (seen_high && en) begin
            busy <= 1'b1;
            ph   <= '0;
            idx  <= '0;
          end
        end
      end else if (tick) begin
        if (ph == PH_W'(OVS - 1)) begin
          ph  <= '0;
          idx <= idx + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
        if (ph == PH_W'(SMP_A)) sa <= s2;
        if (ph == PH_W'(SMP_B)) sb <= s2;
        if (ph == PH_W'(SMP_C)) begin
          if (idx == 4'd0) begin
            if (vote) busy <= 1'b0;
          end else if (idx == stop_idx) begin
            busy      <= 1'b0;
            seen_high <= 1'b0;
            valid     <= 1'b1;
            data      <= nine ? sh : {1'b0, sh[8:1]};
            ferr      <= ~vote;
            perr      <= par_en & ((nine ? ^sh : ^sh[8:1]) ^ par_odd);
          end else begin
            sh <= {vote, sh[8:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sci_pinmux.sv
module sci_pinmux (
  input  logic clk,
  input  logic rst,
  input  logic loop_en,
  input  logic od_en,
  input  logic src_pad,
  input  logic tx_en,
  input  logic rx_en,
  input  logic txd_dir,
  input  logic rxd_dir,
  input  logic rxd_gpio,
  input  logic tx_line,
  input  logic txd_in,
  input  logic rxd_in,
  output logic rx_src,
  output logic txd_o,
  output logic txd_oe,
  output logic txd_od,
  output logic rxd_o,
  output logic rxd_oe,
  output logic rxd_od
);
  logic looped, t_val, t_drv, r_val, r_drv;

  assign looped = loop_en & tx_en & rx_en;
  assign rx_src = !looped ? rxd_in : (src_pad ? txd_in : tx_line);

  always_comb begin
    if (!looped) begin
      t_val = tx_line;  t_drv = tx_en;
      r_val = 1'b1;     r_drv = 1'b0;
    end else begin
      t_val = txd_dir ? tx_line : 1'b1;
      t_drv = txd_dir | ~src_pad;
      r_val = rxd_gpio;
      r_drv = rxd_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_o <= 1'b1; txd_oe <= 1'b0; txd_od <= 1'b0;
      rxd_o <= 1'b1; rxd_oe <= 1'b0; rxd_od <= 1'b0;
    end else begin
      txd_o  <= t_val;
      txd_oe <= t_drv & (~od_en | ~t_val);
      txd_od <= od_en;
      rxd_o  <= r_val;
      rxd_oe <= r_drv & (~od_en | ~r_val);
      rxd_od <= od_en;
    end
  end
endmodule

// File: rtl/sci_loopwire.sv
module sci_loopwire
  import sci_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       txd_dir,
  input  logic       rxd_dir,
  input  logic       rxd_gpio,
  input  logic [8:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [8:0] rx_data,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_valid,
  input  logic       rx_ready,
  input  logic       txd_in,
  input  logic       rxd_in,
  output logic       txd_o,
  output logic       txd_oe,
  output logic       txd_od,
  output logic       rxd_o,
  output logic       rxd_oe,
  output logic       rxd_od
);
  ctl_t ctl;
  logic tick, tx_line, rx_src;

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '0;
    else if (cfg_we) ctl <= ctl_t'(cfg_wdata);
  end
  assign cfg_rdata = ctl;

  sci_baud #(.TICK_DIV(TICK_DIV)) u_baud (.clk(clk), .rst(rst), .tick(tick));

  sci_tx u_tx (
    .clk(clk), .rst(rst), .tick(tick), .en(tx_en),
    .nine(ctl.nine), .par_en(ctl.par_en), .par_odd(ctl.par_odd),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready), .line(tx_line)
  );

  sci_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(rx_en),
    .nine(ctl.nine), .par_en(ctl.par_en), .par_odd(ctl.par_odd),
    .line_in(rx_src), .data(rx_data), .valid(rx_valid), .ready(rx_ready),
    .perr(rx_perr), .ferr(rx_ferr)
  );

  sci_pinmux u_pins (
    .clk(clk), .rst(rst), .loop_en(ctl.loop_en), .od_en(ctl.od_en),
    .src_pad(ctl.src_pad), .tx_en(tx_en), .rx_en(rx_en),
    .txd_dir(txd_dir), .rxd_dir(rxd_dir), .rxd_gpio(rxd_gpio),
    .tx_line(tx_line), .txd_in(txd_in), .rxd_in(rxd_in), .rx_src(rx_src),
    .txd_o(txd_o), .txd_oe(txd_oe), .txd_od(txd_od),
    .rxd_o(rxd_o), .rxd_oe(rxd_oe), .rxd_od(rxd_od)
  );
endmodule

// File: rtl/sci_loopwire_chk.sv
module sci_loopwire_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cfg_rdata,
  input logic       tx_en,
  input logic       rx_en,
  input logic       txd_dir,
  input logic       rxd_dir,
  input logic       rxd_gpio,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       txd_o,
  input logic       txd_oe,
  input logic       txd_od,
  input logic       rxd_o,
  input logic       rxd_oe,
  input logic       rxd_od
);
  logic looped;
  assign looped = cfg_rdata[7] & tx_en & rx_en;

  p_cfg_reset_r1: assert property (@(posedge clk) rst |=> (cfg_rdata == 8'h00));

  p_hold_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid);

  p_rxd_input_r6: assert property (@(posedge clk) disable iff (rst)
    !looped |=> !rxd_oe);

  p_idle_high_r7: assert property (@(posedge clk) disable iff (rst)
    (looped && !txd_dir && !cfg_rdata[5] && !cfg_rdata[6]) |=> (txd_oe && txd_o));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (looped && !txd_dir && cfg_rdata[5]) |=> !txd_oe);

  p_gpio_r9: assert property (@(posedge clk) disable iff (rst)
    (looped && !cfg_rdata[6]) |=> (rxd_oe == $past(rxd_dir) && rxd_o == $past(rxd_gpio)));

  p_od_txd_r10: assert property (@(posedge clk) disable iff (rst)
    (txd_oe && txd_od) |-> !txd_o);

  p_od_rxd_r10: assert property (@(posedge clk) disable iff (rst)
    (rxd_oe && rxd_od) |-> !rxd_o);
endmodule

bind sci_loopwire sci_loopwire_chk i_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .tx_en(tx_en), .rx_en(rx_en),
  .txd_dir(txd_dir), .rxd_dir(rxd_dir), .rxd_gpio(rxd_gpio),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .txd_o(txd_o), .txd_oe(txd_oe), .txd_od(txd_od),
  .rxd_o(rxd_o), .rxd_oe(rxd_oe), .rxd_od(rxd_od)
);

// File: tb/test_sci_loopwire.sv
module test_sci_loopwire;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic tx_en = 1'b0, rx_en = 1'b0, txd_dir = 1'b0, rxd_dir = 1'b0, rxd_gpio = 1'b0;
  logic [8:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_ready, rx_perr, rx_ferr, rx_valid, rx_ready = 1'b0;
  logic txd_in, rxd_drv = 1'b1;
  logic txd_o, txd_oe, txd_od, rxd_o, rxd_oe, rxd_od;

  int n_chk = 0, n_fail = 0;
  logic low_seen;

  always #10 clk = ~clk;
  assign txd_in = txd_oe ? txd_o : 1'b1;

  sci_loopwire #(.TICK_DIV(DIV)) i_sci_loopwire (
    .clk, .rst, .cfg_we, .cfg_wdata, .cfg_rdata, .tx_en, .rx_en, .txd_dir, .rxd_dir,
    .rxd_gpio, .tx_data, .tx_valid, .tx_ready, .rx_data, .rx_perr, .rx_ferr, .rx_valid,
    .rx_ready, .txd_in, .rxd_in(rxd_drv), .txd_o, .txd_oe, .txd_od, .rxd_o, .rxd_oe, .rxd_od
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_body(input logic [8:0] d, input bit m, input bit pe, input bit pt);
    logic [8:0] r;
    logic p;
    int n;
    n = m ? 9 : 8;
    r = m ? d : {1'b0, d[7:0]};
    if (pe) begin
      p = pt;
      for (int i = 0; i < n - 1; i++) p ^= d[i];
      r[n-1] = p;
    end
    return r;
  endfunction

  task automatic wcfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic get_rx(input int lim, output bit got, output logic [8:0] d,
                        output logic pe, output logic fe);
    got = 0; d = '0; pe = 0; fe = 0;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk);
      if (txd_oe && !txd_o) low_seen = 1'b1;
      if (rx_valid) begin
        got = 1; d = rx_data; pe = rx_perr; fe = rx_ferr;
        rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
      end
    end
  endtask

  task automatic drive_frame(input logic [10:0] f, input int nb);
    for (int i = 0; i < nb; i++) begin
      rxd_drv = f[i];
      repeat (BIT) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic decode_txd(input int nb, output logic [10:0] f);
    int guard;
    f = '1; guard = 0;
    while (txd_o && guard < 4 * BIT) begin @(negedge clk); guard++; end
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      f[i] = txd_o;
      repeat (BIT) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit got;
    logic [8:0] d, e;
    logic pe, fe;
    logic [10:0] f, fe_exp;
    logic [8:0] vals [4];
    vals[0] = 9'h000; vals[1] = 9'h1FF; vals[2] = 9'h0A5; vals[3] = 9'h15A;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset cfg", cfg_rdata == 8'h00, cfg_rdata, 0);
    chk("R5 txd_oe off with tx_en=0", txd_oe == 1'b0, txd_oe, 0);
    chk("R4 no rx_valid at reset", rx_valid == 1'b0, rx_valid, 0);
    chk("R12 tx_ready low with tx_en=0", tx_ready == 1'b0, tx_ready, 0);

    wcfg(8'h5A);
    chk("R1 readback", cfg_rdata == 8'h5A, cfg_rdata, 8'h5A);
    wcfg(8'h00);

    tx_en = 1'b1; rx_en = 1'b1; rxd_dir = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 txd idle driven high", txd_oe && txd_o, {txd_oe, txd_o}, 3);
    chk("R5 rxd input in normal", rxd_oe == 1'b0, rxd_oe, 0);
    chk("R12 tx_ready when idle", tx_ready == 1'b1, tx_ready, 1);

    // R2 R3: decode transmit waveform in every frame option
    for (int c = 0; c < 8; c++) begin
      bit m, p, t;
      m = c[2]; p = c[1]; t = c[0];
      wcfg({3'b000, m, 2'b00, p, t});
      send(9'h0B6);
      decode_txd(m ? 11 : 10, f);
      e = exp_body(9'h0B6, m, p, t);
      fe_exp = m ? {1'b1, e, 1'b0} : {2'b11, e[7:0], 1'b0};
      chk("R2 R3 tx waveform", f == fe_exp, f, fe_exp);
      repeat (2 * BIT) @(negedge clk);
    end

    // R4 R3: frames injected on rxd_in, 8 bits with even parity
    wcfg(8'h02);
    e = exp_body(9'h035, 0, 1, 0);
    drive_frame({2'b11, e[7:0], 1'b0}, 10);
    get_rx(BIT, got, d, pe, fe);
    chk("R4 good frame data", got && d == e && !pe && !fe, d, e);
    drive_frame({2'b11, ~e[7], e[6:0], 1'b0}, 10);
    get_rx(BIT, got, d, pe, fe);
    chk("R3 parity error flagged", got && pe && !fe, {pe, fe}, 2);
    drive_frame({2'b10, e[7:0], 1'b0}, 10);
    get_rx(BIT, got, d, pe, fe);
    chk("R4 framing error flagged", got && fe, fe, 1);
    rxd_drv = 1'b0; repeat (3 * DIV) @(negedge clk); rxd_drv = 1'b1;
    get_rx(12 * BIT, got, d, pe, fe);
    chk("R4 start glitch rejected", !got, got, 0);
    wcfg(8'h10);
    drive_frame({1'b1, 9'h1C3, 1'b0}, 11);
    get_rx(BIT, got, d, pe, fe);
    chk("R2 nine-bit receive", got && d == 9'h1C3, d, 9'h1C3);

    // R7 R1: internal loop sweep, stored-only bits set
    txd_dir = 1'b1;
    for (int c = 0; c < 8; c++) begin
      bit m, p, t;
      m = c[2]; p = c[1]; t = c[0];
      wcfg({3'b100, m, 2'b11, p, t});
      for (int k = 0; k < 4; k++) begin
        send(vals[k]);
        get_rx(20 * BIT, got, d, pe, fe);
        e = exp_body(vals[k], m, p, t);
        chk("R7 R1 internal loop data", got && d == e && !pe && !fe, d, e);
      end
    end

    // R6: loop not active while rx_en=0
    wcfg(8'h80);
    rx_en = 1'b0; rxd_gpio = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 rxd stays input without rx_en", rxd_oe == 1'b0, rxd_oe, 0);
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 rxd gpio driven low", rxd_oe && !rxd_o, {rxd_oe, rxd_o}, 2);
    rxd_gpio = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 rxd gpio driven high", rxd_oe && rxd_o, {rxd_oe, rxd_o}, 3);
    @(negedge clk); rxd_gpio = 1'b0; #1;
    chk("R11 rxd_o not yet changed", rxd_o == 1'b1, rxd_o, 1);
    @(negedge clk);
    chk("R11 rxd_o changed after one edge", rxd_o == 1'b0, rxd_o, 0);

    // R7: txd_dir=0 holds pad high while loop still works
    txd_dir = 1'b0;
    repeat (2) @(negedge clk);
    low_seen = 1'b0;
    send(9'h03C);
    get_rx(20 * BIT, got, d, pe, fe);
    chk("R7 loop data with pad idle", got && d == 9'h03C, d, 9'h03C);
    chk("R7 pad held high during frame", !low_seen && txd_oe && txd_o, {low_seen, txd_oe, txd_o}, 3);

    // R8: single-wire through the pad
    wcfg(8'hA0);
    txd_dir = 1'b1;
    for (int k = 0; k < 4; k++) begin
      send(vals[k]);
      get_rx(20 * BIT, got, d, pe, fe);
      e = exp_body(vals[k], 0, 0, 0);
      chk("R8 single-wire data", got && d == e, d, e);
    end
    txd_dir = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 pad released", txd_oe == 1'b0, txd_oe, 0);
    send(9'h055);
    get_rx(15 * BIT, got, d, pe, fe);
    chk("R8 nothing received from released pad", !got, got, 0);

    // R10: wired-OR drive
    wcfg(8'hC0);
    repeat (2) @(negedge clk);
    chk("R10 idle high not driven", !txd_oe && txd_od && txd_o, {txd_oe, txd_od, txd_o}, 3);
    rxd_gpio = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 rxd high released", !rxd_oe && rxd_od, {rxd_oe, rxd_od}, 1);
    rxd_gpio = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 rxd low driven", rxd_oe && !rxd_o, {rxd_oe, rxd_o}, 2);
    txd_dir = 1'b1; low_seen = 1'b0;
    send(9'h0E1);
    get_rx(20 * BIT, got, d, pe, fe);
    chk("R10 loop data with open drain", got && d == 9'h0E1 && low_seen, d, 9'h0E1);

    tx_en = 1'b0;
    @(negedge clk);
    chk("R12 tx_ready drops with tx_en", tx_ready == 1'b0, tx_ready, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule